// File: doc/BRIEF.md
# Multi-Width Two-Operand ALU with Flag Update

This block is the execute stage of a small 20-bit processor. It takes a four-bit operation code, a source and a destination operand, a two-bit size code and the incoming carry. From these it produces a result, a write-enable for that result, and the next values of the four status bits V, N, Z and C. Each status bit comes with its own update mask, so the register file only changes the flags that the operation defines.

There are twelve two-operand operations: move, binary add with or without carry, subtract with or without carry, compare, packed-BCD add, bit test, bit clear, bit set, exclusive-or and and. Each one runs at byte (8-bit), word (16-bit) or address (20-bit) width. Operand bits above the active width are ignored. The result is zero-extended above that width, and every flag refers only to the active width.

The arithmetic and logic are combinational. A single register stage holds the result, write-enable, flags and masks, so the outputs describe the operation presented one clock edge earlier.

Top module: `alu20`

## Requirements
- R1: Operation codes are MOV=4, ADD=5, ADDC=6, SUBC=7, SUB=8, CMP=9, DADD=10, BIT=11, BIC=12, BIS=13, XOR=14, AND=15. MOV writes src, BIC writes NOT(src) AND dst, and BIS writes src OR dst. All three raise the write-enable, set the flag mask to 0000 and drive the flag outputs to 0000. For every operation, a flag output bit whose mask bit is 0 reads 0.
- R2: ADD writes src+dst and ADDC writes src+dst+C. C is the carry out of the active top bit, and V is signed overflow at the active width. The flag mask is 1111 (order V,N,Z,C from bit 3 down to bit 0).
- R3: SUB writes dst+NOT(src)+1 and SUBC writes dst+NOT(src)+C. C is the carry out of the active top bit, which means C=1 when there is no borrow. V is signed overflow of that addition. The flag mask is 1111.
- R4: CMP computes the same value and flags as SUB, with a flag mask of 1111. It drives the write-enable low, and the computed value still appears on the result output.
- R5: DADD adds src+dst+C as packed BCD and writes the decimal sum modulo 10^(width/4). C=1 exactly when the decimal sum exceeds 99, 9999 or 99999 at the active width. V=0, and the flag mask is 1111.
- R6: AND and BIT compute src AND dst, set V=0 and set C to the inverse of Z, with a flag mask of 1111. AND writes its result. BIT drives the write-enable low.
- R7: XOR writes src XOR dst and sets C to the inverse of Z. V=1 exactly when both masked operands have their active top bit set. The flag mask is 1111.
- R8: Size code 11 selects byte width, 10 selects word width and 01 selects address width. Code 00 behaves as word width. Operand bits above the active width have no effect, and result bits above it are 0.
- R9: N is the result bit at the top of the active width. Z=1 exactly when the result is zero within the active width.
- R10: Codes 0 to 3 are undefined. They give result 0, write-enable 0, flag mask 0000 and flags 0000.
- R11: All outputs register the operation presented at the previous rising clock edge. An active-low asynchronous reset forces all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| sz_i | input | 2 | Size code |
| src_i | input | 20 | Source operand |
| dst_i | input | 20 | Destination operand |
| c_i | input | 1 | Incoming carry flag |
| res_o | output | 20 | Result, zero-extended above active width |
| wr_o | output | 1 | Result write-enable |
| flg_o | output | 4 | Next flags {V,N,Z,C} |
| fmask_o | output | 4 | Per-flag update mask {V,N,Z,C} |

## Verification
Carry out of the active width and a zero result can occur in the same cycle. For example, a byte ADD of FF and 01 wraps to 00, so C and Z must both be set while the random bits above bit 7 of each operand are ignored. The bench drives every operation at all three widths against the all-ones, top-bit and top-bit-minus-one operand boundaries, with and without an incoming carry. This makes carry, zero, sign and overflow collide in one result. Each collision is judged against an arithmetic model of the active width that is computed in the bench.

// File: rtl/alu20_pkg.sv
package alu20_pkg;

   typedef enum logic [3:0] {
      OP_MOV  = 4'd4,
      OP_ADD  = 4'd5,
      OP_ADDC = 4'd6,
      OP_SUBC = 4'd7,
      OP_SUB  = 4'd8,
      OP_CMP  = 4'd9,
      OP_DADD = 4'd10,
      OP_BIT  = 4'd11,
      OP_BIC  = 4'd12,
      OP_BIS  = 4'd13,
      OP_XOR  = 4'd14,
      OP_AND  = 4'd15
   } alu_op_e;

   typedef enum logic [1:0] {
      SZ_RSV  = 2'b00,
      SZ_ADDR = 2'b01,
      SZ_WORD = 2'b10,
      SZ_BYTE = 2'b11
   } alu_sz_e;

   // flag vector positions
   localparam int FLG_C = 0;
   localparam int FLG_Z = 1;
   localparam int FLG_N = 2;
   localparam int FLG_V = 3;

   localparam logic [3:0] FLG_ALL  = 4'hF;
   localparam logic [3:0] FLG_NONE = 4'h0;

endpackage

// File: rtl/alu20_binadd.sv
module alu20_binadd #(
   parameter int W = 20
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W:0]   sum_o
);

   assign sum_o = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};

endmodule

// File: rtl/alu20_bcdadd.sv
module alu20_bcdadd #(
   parameter int W = 20
) (
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   input  logic           cin_i,
   output logic [W-1:0]   sum_o,
   output logic [W/4-1:0] dc_o
);

   localparam int ND = W / 4;

   logic [ND:0] chain;
   assign chain[0] = cin_i;

   for (genvar g = 0; g < ND; g++) begin : g_digit
      logic [4:0] raw;
      logic       over;
      assign raw  = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + {4'd0, chain[g]};
      assign over = raw > 5'd9;
      assign sum_o[4*g +: 4] = over ? 4'(raw + 5'd6) : raw[3:0];
      assign chain[g+1] = over;
      assign dc_o[g]    = over;
   end

endmodule

// File: rtl/alu20_bitwise.sv
module alu20_bitwise #(
   parameter int W = 20
) (
   input  logic [W-1:0] s_i,
   input  logic [W-1:0] d_i,
   input  logic [W-1:0] m_i,
   output logic [W-1:0] and_o,
   output logic [W-1:0] bic_o,
   output logic [W-1:0] bis_o,
   output logic [W-1:0] xor_o
);

   assign and_o = s_i & d_i;
   assign bic_o = ~s_i & d_i & m_i;
   assign bis_o = s_i | d_i;
   assign xor_o = s_i ^ d_i;

endmodule

// File: rtl/alu20.sv
module alu20
   import alu20_pkg::*;
#(
   parameter int DATA_W = 20,
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_i,
   input  logic [1:0]        sz_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic              c_i,
   output logic [DATA_W-1:0] res_o,
   output logic              wr_o,
   output logic [3:0]        flg_o,
   output logic [3:0]        fmask_o
);

   localparam int ND = DATA_W / 4;
   localparam logic [DATA_W-1:0] M_ADDR = {DATA_W{1'b1}};
   localparam logic [DATA_W-1:0] M_WORD = {DATA_W{1'b1}} >> (DATA_W - WORD_W);
   localparam logic [DATA_W-1:0] M_BYTE = {DATA_W{1'b1}} >> (DATA_W - BYTE_W);
   localparam logic [ND-1:0] DS_ADDR = ND'(1) << (ND - 1);
   localparam logic [ND-1:0] DS_WORD = ND'(1) << (WORD_W / 4 - 1);
   localparam logic [ND-1:0] DS_BYTE = ND'(1) << (BYTE_W / 4 - 1);

   if ((DATA_W % 4) != 0 || (WORD_W % 4) != 0 || (BYTE_W % 4) != 0 ||
       BYTE_W < 4 || BYTE_W >= WORD_W || WORD_W >= DATA_W) begin : g_cfg_bad
      $error("alu20: widths must be multiples of 4 with BYTE_W < WORD_W < DATA_W");
   end

   alu_op_e           op;
   logic [DATA_W-1:0] wmask, msbv;
   logic [ND-1:0]     dsel;
   logic [DATA_W-1:0] s, d, sn, a_add;
   logic              is_sub, cin;
   logic [DATA_W:0]   bsum;
   logic [DATA_W-1:0] dsum;
   logic [ND-1:0]     dcar;
   logic [DATA_W-1:0] v_and, v_bic, v_bis, v_xor;
   logic              c_bin, c_dec, v_add, v_xr;

   assign op = alu_op_e'(op_i);

   // active width selection
   always_comb begin
      case (alu_sz_e'(sz_i))
         SZ_BYTE: begin wmask = M_BYTE; dsel = DS_BYTE; c_bin = bsum[BYTE_W]; end
         SZ_ADDR: begin wmask = M_ADDR; dsel = DS_ADDR; c_bin = bsum[DATA_W]; end
         default: begin wmask = M_WORD; dsel = DS_WORD; c_bin = bsum[WORD_W]; end
      endcase
   end

   assign msbv  = wmask ^ (wmask >> 1);
   assign s     = src_i & wmask;
   assign d     = dst_i & wmask;
   assign sn    = ~src_i & wmask;
   assign is_sub = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
   assign a_add = is_sub ? sn : s;

   always_comb begin
      case (op)
         OP_ADD:          cin = 1'b0;
         OP_SUB, OP_CMP:  cin = 1'b1;
         default:         cin = c_i;
      endcase
   end

   alu20_binadd #(.W(DATA_W)) u_binadd (
      .a_i(a_add), .b_i(d), .cin_i(cin), .sum_o(bsum)
   );

   alu20_bcdadd #(.W(DATA_W)) u_bcdadd (
      .a_i(s), .b_i(d), .cin_i(c_i), .sum_o(dsum), .dc_o(dcar)
   );

   alu20_bitwise #(.W(DATA_W)) u_bitwise (
      .s_i(s), .d_i(d), .m_i(wmask),
      .and_o(v_and), .bic_o(v_bic), .bis_o(v_bis), .xor_o(v_xor)
   );

   assign c_dec = |(dcar & dsel);
   assign v_add = ((|(a_add & msbv)) == (|(d & msbv))) &&
                  ((|(bsum[DATA_W-1:0] & msbv)) != (|(a_add & msbv)));
   assign v_xr  = |(s & d & msbv);

   logic [DATA_W-1:0] raw, r;
   logic              wr, v_n, c_n, c_from_z, n, z;
   logic [3:0]        mk, flg;

   always_comb begin
      raw      = '0;
      wr       = 1'b0;
      mk       = FLG_NONE;
      v_n      = 1'b0;
      c_n      = 1'b0;
      c_from_z = 1'b0;
      case (op)
         OP_MOV: begin raw = s;     wr = 1'b1; end
         OP_BIC: begin raw = v_bic; wr = 1'b1; end
         OP_BIS: begin raw = v_bis; wr = 1'b1; end
         OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
            raw = bsum[DATA_W-1:0];
            wr  = (op != OP_CMP);
            mk  = FLG_ALL;
            v_n = v_add;
            c_n = c_bin;
         end
         OP_DADD: begin raw = dsum; wr = 1'b1; mk = FLG_ALL; c_n = c_dec; end
         OP_AND, OP_BIT: begin
            raw = v_and; wr = (op == OP_AND); mk = FLG_ALL; c_from_z = 1'b1;
         end
         OP_XOR: begin
            raw = v_xor; wr = 1'b1; mk = FLG_ALL; v_n = v_xr; c_from_z = 1'b1;
         end
         default: ;
      endcase
   end

   assign r   = raw & wmask;
   assign n   = |(r & msbv);
   assign z   = (r == '0);
   assign flg = mk & {v_n, n, z, (c_from_z ? ~z : c_n)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_o   <= '0;
         wr_o    <= 1'b0;
         flg_o   <= 4'h0;
         fmask_o <= 4'h0;
      end else begin
         res_o   <= r;
         wr_o    <= wr;
         flg_o   <= flg;
         fmask_o <= mk;
      end
   end

endmodule

// File: rtl/alu20_chk.sv
module alu20_chk
   import alu20_pkg::*;
#(
   parameter int DATA_W = 20,
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        op_i,
   input logic [1:0]        sz_i,
   input logic [DATA_W-1:0] src_i,
   input logic [DATA_W-1:0] dst_i,
   input logic [DATA_W-1:0] res_o,
   input logic              wr_o,
   input logic [3:0]        flg_o,
   input logic [3:0]        fmask_o
);

   logic              armed;
   logic [3:0]        q_op;
   logic [1:0]        q_sz;
   logic [DATA_W-1:0] q_src, q_dst, wm, mv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         q_op  <= 4'h0;
         q_sz  <= 2'b00;
         q_src <= '0;
         q_dst <= '0;
      end else begin
         armed <= 1'b1;
         q_op  <= op_i;
         q_sz  <= sz_i;
         q_src <= src_i;
         q_dst <= dst_i;
      end
   end

   always_comb begin
      case (q_sz)
         2'b11:   wm = {DATA_W{1'b1}} >> (DATA_W - BYTE_W);
         2'b01:   wm = {DATA_W{1'b1}};
         default: wm = {DATA_W{1'b1}} >> (DATA_W - WORD_W);
      endcase
   end
   assign mv = wm ^ (wm >> 1);

   p_quiet_move_r1: assert property (@(posedge clk) disable iff (!rst_n)
      armed && (q_op == OP_MOV || q_op == OP_BIC || q_op == OP_BIS)
      |-> wr_o && fmask_o == 4'h0 && flg_o == 4'h0);

   p_masked_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (flg_o & ~fmask_o) == 4'h0);

   p_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      armed && (q_op == OP_CMP || q_op == OP_BIT) |-> !wr_o && fmask_o == 4'hF);

   p_logic_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      armed && (q_op == OP_AND || q_op == OP_BIT)
      |-> !flg_o[FLG_V] && (flg_o[FLG_C] == !flg_o[FLG_Z]));

   p_xor_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      armed && q_op == OP_XOR
      |-> (flg_o[FLG_C] == !flg_o[FLG_Z]) && (flg_o[FLG_V] == |(q_src & q_dst & mv)));

   p_zero_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (res_o & ~wm) == '0);

   p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      armed && fmask_o[FLG_Z] |-> flg_o[FLG_Z] == (res_o == '0));

   p_sign_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      armed && fmask_o[FLG_N] |-> flg_o[FLG_N] == |(res_o & mv));

   p_undefined_r10: assert property (@(posedge clk) disable iff (!rst_n)
      armed && q_op < 4'd4
      |-> !wr_o && fmask_o == 4'h0 && flg_o == 4'h0 && res_o == '0);

endmodule

bind alu20 alu20_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_i(op_i), .sz_i(sz_i), .src_i(src_i), .dst_i(dst_i),
   .res_o(res_o), .wr_o(wr_o), .flg_o(flg_o), .fmask_o(fmask_o)
);

// File: tb/test_alu20.sv
module test_alu20;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  op_i;
   logic [1:0]  sz_i;
   logic [19:0] src_i, dst_i;
   logic        c_i;
   logic [19:0] res_o;
   logic        wr_o;
   logic [3:0]  flg_o, fmask_o;

   int total = 0;
   int bad   = 0;
   logic [31:0] lf = 32'h1234_5678;

   always #10 clk = ~clk;

   alu20 i_alu20 (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .sz_i(sz_i), .src_i(src_i), .dst_i(dst_i),
      .c_i(c_i), .res_o(res_o), .wr_o(wr_o), .flg_o(flg_o), .fmask_o(fmask_o)
   );

   function automatic logic [31:0] rnd();
      lf ^= lf << 13;
      lf ^= lf >> 17;
      lf ^= lf << 5;
      return lf;
   endfunction

   function automatic longint pow10(int nd);
      longint p = 1;
      for (int k = 0; k < nd; k++) p *= 10;
      return p;
   endfunction

   function automatic longint to_bcd(longint v);
      longint r = 0;
      for (int k = 0; k < 6; k++) begin
         r |= (v % 10) << (4 * k);
         v /= 10;
      end
      return r;
   endfunction

   function automatic longint from_bcd(longint v, int nd);
      longint r = 0, p = 1;
      for (int k = 0; k < nd; k++) begin
         r += ((v >> (4 * k)) & 15) * p;
         p *= 10;
      end
      return r;
   endfunction

   function automatic string tag_of(int op);
      case (op)
         4, 12, 13: return "R1";
         5, 6:      return "R2";
         7, 8:      return "R3";
         9:         return "R4";
         10:        return "R5";
         11, 15:    return "R6";
         14:        return "R7";
         default:   return "R10";
      endcase
   endfunction

   // arithmetic reference of the requirements
   task automatic model(input int op, input int w, input longint src, input longint dst,
                        input bit c, output longint r, output bit wr,
                        output logic [3:0] f, output logic [3:0] mk);
      longint m, msb, s, d, a, sum, p;
      bit v, cc, cz, cin;
      m = (longint'(1) << w) - 1;
      msb = longint'(1) << (w - 1);
      s = src & m;
      d = dst & m;
      r = 0; wr = 0; mk = 4'h0; v = 0; cc = 0; cz = 0;
      case (op)
         4:  begin r = s; wr = 1; end
         12: begin r = (~s) & d & m; wr = 1; end
         13: begin r = s | d; wr = 1; end
         5, 6, 7, 8, 9: begin
            a = (op >= 7) ? ((~s) & m) : s;
            cin = (op == 5) ? 1'b0 : ((op == 8 || op == 9) ? 1'b1 : c);
            sum = a + d + longint'(cin);
            r = sum & m;
            cc = ((sum >> w) & 1) != 0;
            v = (((a & msb) != 0) == ((d & msb) != 0)) && (((r & msb) != 0) != ((a & msb) != 0));
            wr = (op != 9);
            mk = 4'hF;
         end
         10: begin
            p = pow10(w / 4);
            sum = from_bcd(s, w / 4) + from_bcd(d, w / 4) + longint'(c);
            cc = sum > p - 1;
            r = to_bcd(sum % p);
            wr = 1; mk = 4'hF;
         end
         11, 15: begin r = s & d; wr = (op == 15); mk = 4'hF; cz = 1; end
         14: begin
            r = s ^ d; wr = 1; mk = 4'hF; cz = 1;
            v = ((s & msb) != 0) && ((d & msb) != 0);
         end
         default: ;
      endcase
      f = {v, (r & msb) != 0, r == 0, cz ? (r != 0) : cc} & mk;
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic run_vec(input int op, input logic [1:0] sz, input int w,
                          input longint src, input longint dst, input bit c, input string tag);
      longint er;
      bit ewr;
      logic [3:0] ef, em;
      model(op, w, src, dst, c, er, ewr, ef, em);
      op_i = op[3:0]; sz_i = sz; src_i = src[19:0]; dst_i = dst[19:0]; c_i = c;
      @(negedge clk);
      total++;
      if (res_o !== er[19:0] || wr_o !== ewr || flg_o !== ef || fmask_o !== em) begin
         bad++;
         $display("FAIL %s op=%0d w=%0d src=%h dst=%h c=%0d: got res=%h wr=%0d flg=%b mk=%b expected res=%h wr=%0d flg=%b mk=%b",
                  tag, op, w, src[19:0], dst[19:0], c, res_o, wr_o, flg_o, fmask_o,
                  er[19:0], ewr, ef, em);
      end
   endtask

   function automatic longint bval(int i, int w);
      longint m = (longint'(1) << w) - 1;
      longint msb = longint'(1) << (w - 1);
      case (i)
         0: return 0;
         1: return 1;
         2: return m;
         3: return m - 1;
         4: return msb;
         5: return msb - 1;
         6: return 64'h55555 & m;
         default: return 64'hAAAAA & m;
      endcase
   endfunction

   // shape an operand: BCD for decimal add, random bits above the width (R8)
   function automatic longint shape(longint v, int op, int w);
      longint m = (longint'(1) << w) - 1;
      longint p = pow10(w / 4);
      longint o = v;
      if (op == 10) o = (v == m) ? to_bcd(p - 1) : to_bcd(v % p);
      return o | (longint'(rnd()) & 64'hFFFFF & ~m);
   endfunction

   task automatic check_zero(input string tag);
      total++;
      if (res_o !== 20'h0 || wr_o !== 1'b0 || flg_o !== 4'h0 || fmask_o !== 4'h0) begin
         bad++;
         $display("FAIL %s reset: got res=%h wr=%0d flg=%b mk=%b expected all zero",
                  tag, res_o, wr_o, flg_o, fmask_o);
      end
   endtask

   initial begin
      rst_n = 1'b0;
      op_i = 4'd4; sz_i = 2'b01; src_i = 20'hABCDE; dst_i = 20'h0; c_i = 1'b1;
      repeat (3) @(negedge clk);
      check_zero("R11");
      rst_n = 1'b1;
      op_i = 4'd0;
      @(negedge clk);
      @(negedge clk);
      // R11: output changes only at the next rising edge
      op_i = 4'd4; src_i = 20'h12345;
      #2;
      total++;
      if (res_o !== 20'h0) begin
         bad++;
         $display("FAIL R11 latency: got res=%h expected 00000 before edge", res_o);
      end
      @(negedge clk);
      total++;
      if (res_o !== 20'h12345 || wr_o !== 1'b1) begin
         bad++;
         $display("FAIL R11 latency: got res=%h wr=%0d expected 12345 1", res_o, wr_o);
      end

      // sweep: all codes, three widths, both carries, boundary and random operands
      for (int wi = 0; wi < 3; wi++) begin
         int w;
         logic [1:0] sz;
         w  = (wi == 0) ? 8 : ((wi == 1) ? 16 : 20);
         sz = (wi == 0) ? 2'b11 : ((wi == 1) ? 2'b10 : 2'b01);
         for (int op = 0; op < 16; op++) begin
            for (int c = 0; c < 2; c++) begin
               for (int i = 0; i < 8; i++) begin
                  for (int j = 0; j < 8; j++) begin
                     run_vec(op, sz, w, shape(bval(i, w), op, w), shape(bval(j, w), op, w),
                             c[0], {tag_of(op), "/R8/R9"});
                  end
               end
               for (int k = 0; k < 16; k++) begin
                  longint m;
                  m = (longint'(1) << w) - 1;
                  run_vec(op, sz, w, shape(longint'(rnd()) & m, op, w),
                          shape(longint'(rnd()) & m, op, w), c[0], {tag_of(op), "/R8/R9"});
               end
            end
         end
      end

      // R8: reserved size code behaves as word
      for (int op = 4; op < 16; op++) begin
         for (int k = 0; k < 8; k++) begin
            run_vec(op, 2'b00, 16, shape(longint'(rnd()) & 64'hFFFF, op, 16),
                    shape(longint'(rnd()) & 64'hFFFF, op, 16), k[0], "R8");
         end
      end

      // R11: asynchronous reset in mid-run
      op_i = 4'd13; sz_i = 2'b01; src_i = 20'hF0F0F; dst_i = 20'h1; c_i = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_zero("R11");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_vec(5, 2'b11, 8, 20'h3F0FF, 20'h00001, 1'b0, "R2/R9");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule